// File: doc/BRIEF.md
# Debug External Event Pin Controller

This block sits in a processor debug unit and governs seven bidirectional external event pins: six numbered pins (0 to 5) and one pin tied to the data detection channel. A 16-bit control register assigns each pin a 2-bit mode. In an input mode, a pin can hold its matching detection channel enabled or fire one-cycle event pulses toward the debug sequencer (debug entry, debug exception, trace start, trace stop). A pin can also gate the event counter. In output mode, the mailbox pin signals that the core has written the transmit mailbox and the host has not yet finished reading it.

Pin inputs are asynchronous to the core clock. A synchronizer and an edge detector sit in front of each pin. The register resets to all ones, so every pin starts as an input that forces debug entry. A host that holds pin 0 high through reset therefore sees the core stopped in debug state right after reset. The same path takes the core out of a wait or stop state, because the pulse does not depend on the core running.

Top module: `dbg_evpin_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `reg_rdata` reads 16'hFFFC, `pin_oe` is 0, and every enable and event output is 0.
- R2: A write stores bits [15:2] of `reg_wdata`, and the stored value reads back on `reg_rdata` after the write edge. Bits [1:0] always read 0. Numbered pin k takes its mode from bits [2k+3:2k+2], and the data pin takes its mode from bits [15:14].
- R3: Mode 2'b11 (debug entry) makes a rising edge on the pin produce a one-cycle `dbg_enter_pls`. The pulse is visible after the third rising clock edge that follows the input change. A level held high gives only one pulse.
- R4: Mode 2'b01 makes a rising edge on the pin produce a one-cycle `dbg_exc_pls`, with the same latency as R3.
- R5: Mode 2'b00 makes `addr_ch_en[k]` (numbered pin k) or `data_ch_en` (data pin) follow the synchronized pin level, with the same latency as R3. In every other mode that enable stays 0.
- R6: Mode 2'b10 sets the pin's `pin_oe` bit one cycle after the register holds that mode. While a pin is in mode 2'b10, its input causes no enable, no pulse and no counter gating. Any pin other than pin 4 drives `pin_out` 0 in mode 2'b10.
- R7: When pin 4 is in mode 2'b10, `pin_out[4]` shows the mailbox flag. A pulse on `mbx_core_wr` sets the flag and a pulse on `mbx_host_rd_done` clears it. When both arrive in the same cycle, the flag is set. The change is visible after that edge.
- R8: A rising edge on a pin in any input mode also pulses `trc_on_pls` if the pin is in the trace-start mask (default: pin 2), and pulses `trc_off_pls` if the pin is in the trace-stop mask (default: pin 3). These pulses come in the same cycle as the mode's own event.
- R9: `evcnt_en` is high while any input-mode pin in the counter mask (default: pins 2 and 6) has a high synchronized level.
- R10: If pin 0 is held high through reset while the register is at its reset value, one `dbg_enter_pls` appears after the third clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read value |
| pin_in | input | 7 | Sampled pin levels; bit 6 is the data pin |
| pin_out | output | 7 | Pin drive values |
| pin_oe | output | 7 | Pin output enables |
| mbx_core_wr | input | 1 | Core wrote the transmit mailbox |
| mbx_host_rd_done | input | 1 | Host finished reading the transmit mailbox |
| addr_ch_en | output | 6 | Address detection channel enables |
| data_ch_en | output | 1 | Data detection channel enable |
| evcnt_en | output | 1 | Event counter enable |
| dbg_enter_pls | output | 1 | Debug entry request pulse |
| dbg_exc_pls | output | 1 | Debug exception request pulse |
| trc_on_pls | output | 1 | Trace start pulse |
| trc_off_pls | output | 1 | Trace stop pulse |

## Verification
The assertions check on every cycle that:
- the reserved read bits stay 0;
- the output enables match the mode held in the register one cycle earlier;
- no pin drives a channel enable while it is an output;
- only pin 4 can drive a nonzero value;
- the mailbox pin follows the set and clear handshakes.

The synchronizer latency, the single pulse per edge, the trace and counter masks acting together with a mode's own event, and the debug entry caused by a pin held through reset can only be shown by the bench. It sweeps every mode on every pin and compares the outputs at the exact cycles computed for each case.

// File: rtl/evpin_pkg.sv
package evpin_pkg;

  typedef enum logic [1:0] {
    PM_CHAN = 2'b00,
    PM_EXC  = 2'b01,
    PM_OUT  = 2'b10,
    PM_DBG  = 2'b11
  } pin_mode_e;

  function automatic logic mode_is_input(input logic [1:0] m);
    return m != PM_OUT;
  endfunction

endpackage

// File: rtl/evpin_cfg_reg.sv
module evpin_cfg_reg #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned NPIN  = 7,
  parameter int unsigned FLD_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic [NPIN-1:0][FLD_W-1:0]  mode_o
);
  localparam int unsigned STORE_W = NPIN * FLD_W;
  localparam int unsigned RSV_W   = REG_W - STORE_W;

  logic [STORE_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '1;
    end else if (wr_en) begin
      store_q <= wdata[REG_W-1:RSV_W];
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = ^wdata[RSV_W-1:0];
      assign rdata = {store_q, {RSV_W{1'b0}}};
    end else begin : g_norsv
      assign rdata = store_q;
    end
  endgenerate

  assign mode_o = store_q;

endmodule

// File: rtl/evpin_sync.sv
module evpin_sync #(
  parameter int unsigned NPIN   = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] level_o,
  output logic [NPIN-1:0] rise_o
);
  generate
    for (genvar k = 0; k < NPIN; k++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      logic              prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
          prev_q  <= 1'b0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], pin_i[k]};
          prev_q  <= chain_q[STAGES-1];
        end
      end
      assign level_o[k] = chain_q[STAGES-1];
      assign rise_o[k]  = chain_q[STAGES-1] & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/evpin_mailbox.sv
module evpin_mailbox (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic full_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full_o <= 1'b0;
    end else if (set_i) begin
      full_o <= 1'b1;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evpin_event_map.sv
module evpin_event_map
  import evpin_pkg::*;
#(
  parameter int unsigned NPIN        = 7,
  parameter int unsigned FLD_W       = 2,
  parameter int unsigned TRC_ON_MASK = 'b0000100,
  parameter int unsigned TRC_OFF_MASK= 'b0001000,
  parameter int unsigned CNT_MASK    = 'b1000100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPIN-1:0][FLD_W-1:0] mode_i,
  input  logic [NPIN-1:0]            level_i,
  input  logic [NPIN-1:0]            rise_i,
  output logic [NPIN-1:0]            chan_en_o,
  output logic [NPIN-1:0]            oe_o,
  output logic                       cnt_en_o,
  output logic                       dbg_o,
  output logic                       exc_o,
  output logic                       ton_o,
  output logic                       toff_o
);
  logic [NPIN-1:0] chan_d, oe_d;
  logic            cnt_d, dbg_d, exc_d, ton_d, toff_d;

  always_comb begin
    chan_d = '0;
    oe_d   = '0;
    cnt_d  = 1'b0;
    dbg_d  = 1'b0;
    exc_d  = 1'b0;
    ton_d  = 1'b0;
    toff_d = 1'b0;
    for (int k = 0; k < NPIN; k++) begin
      if (mode_is_input(mode_i[k])) begin
        chan_d[k] = (mode_i[k] == PM_CHAN) && level_i[k];
        dbg_d  = dbg_d  | ((mode_i[k] == PM_DBG) && rise_i[k]);
        exc_d  = exc_d  | ((mode_i[k] == PM_EXC) && rise_i[k]);
        ton_d  = ton_d  | (TRC_ON_MASK[k]  && rise_i[k]);
        toff_d = toff_d | (TRC_OFF_MASK[k] && rise_i[k]);
        cnt_d  = cnt_d  | (CNT_MASK[k]     && level_i[k]);
      end else begin
        oe_d[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en_o <= '0;
      oe_o      <= '0;
      cnt_en_o  <= 1'b0;
      dbg_o     <= 1'b0;
      exc_o     <= 1'b0;
      ton_o     <= 1'b0;
      toff_o    <= 1'b0;
    end else begin
      chan_en_o <= chan_d;
      oe_o      <= oe_d;
      cnt_en_o  <= cnt_d;
      dbg_o     <= dbg_d;
      exc_o     <= exc_d;
      ton_o     <= ton_d;
      toff_o    <= toff_d;
    end
  end

endmodule

// File: rtl/dbg_evpin_ctrl.sv
module dbg_evpin_ctrl #(
  parameter int unsigned NUM_PINS     = 6,
  parameter int unsigned FLD_W        = 2,
  parameter int unsigned REG_W        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned MBX_PIN      = 4,
  parameter int unsigned TRC_ON_MASK  = 'b0000100,
  parameter int unsigned TRC_OFF_MASK = 'b0001000,
  parameter int unsigned CNT_MASK     = 'b1000100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NUM_PINS:0]     pin_in,
  output logic [NUM_PINS:0]     pin_out,
  output logic [NUM_PINS:0]     pin_oe,
  input  logic                  mbx_core_wr,
  input  logic                  mbx_host_rd_done,
  output logic [NUM_PINS-1:0]   addr_ch_en,
  output logic                  data_ch_en,
  output logic                  evcnt_en,
  output logic                  dbg_enter_pls,
  output logic                  dbg_exc_pls,
  output logic                  trc_on_pls,
  output logic                  trc_off_pls
);
  localparam int unsigned NPIN = NUM_PINS + 1;

  logic [NPIN-1:0][FLD_W-1:0] mode;
  logic [NPIN-1:0]            level, rise, chan_en;
  logic                       mbx_full;

  evpin_cfg_reg #(.REG_W(REG_W), .NPIN(NPIN), .FLD_W(FLD_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_o(mode)
  );

  evpin_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in), .level_o(level), .rise_o(rise)
  );

  evpin_mailbox u_mbx (
    .clk(clk), .rst(rst), .set_i(mbx_core_wr), .clr_i(mbx_host_rd_done),
    .full_o(mbx_full)
  );

  evpin_event_map #(
    .NPIN(NPIN), .FLD_W(FLD_W), .TRC_ON_MASK(TRC_ON_MASK),
    .TRC_OFF_MASK(TRC_OFF_MASK), .CNT_MASK(CNT_MASK)
  ) u_map (
    .clk(clk), .rst(rst), .mode_i(mode), .level_i(level), .rise_i(rise),
    .chan_en_o(chan_en), .oe_o(pin_oe), .cnt_en_o(evcnt_en),
    .dbg_o(dbg_enter_pls), .exc_o(dbg_exc_pls),
    .ton_o(trc_on_pls), .toff_o(trc_off_pls)
  );

  assign addr_ch_en = chan_en[NUM_PINS-1:0];
  assign data_ch_en = chan_en[NUM_PINS];

  generate
    for (genvar k = 0; k < NPIN; k++) begin : g_drv
      if (k == MBX_PIN) begin : g_mbx
        assign pin_out[k] = pin_oe[k] & mbx_full;
      end else begin : g_zero
        assign pin_out[k] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/evpin_ctrl_chk.sv
module evpin_ctrl_chk #(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned FLD_W    = 2,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned MBX_PIN  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [REG_W-1:0]    reg_rdata,
  input logic [NUM_PINS:0]   pin_out,
  input logic [NUM_PINS:0]   pin_oe,
  input logic [NUM_PINS-1:0] addr_ch_en,
  input logic                data_ch_en,
  input logic                mbx_core_wr,
  input logic                mbx_host_rd_done
);
  localparam int unsigned NPIN  = NUM_PINS + 1;
  localparam int unsigned RSV_W = REG_W - NPIN * FLD_W;

  logic [NPIN-1:0] oe_exp;
  logic [NPIN-1:0] ch_all;
  always_comb begin
    for (int k = 0; k < NPIN; k++) begin
      oe_exp[k] = reg_rdata[RSV_W + FLD_W*k +: FLD_W] == 2'b10;
    end
  end
  assign ch_all = {data_ch_en, addr_ch_en};

  // R2: reserved bits never read back as one
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[RSV_W-1:0] == '0);

  // R6: output enables track the stored modes one cycle later
  assert_oe_follows_R6: assert property (@(posedge clk) disable iff (rst)
    pin_oe == $past(oe_exp));

  // R6: an output pin never enables a detection channel
  assert_out_no_chan_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_all & pin_oe) == '0);

  // R6: only the mailbox pin may drive a one
  assert_only_mbx_drives_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~(NPIN'(1) << MBX_PIN)) == '0);

  // R7: a core write shows on the mailbox pin when it is an output
  assert_mbx_set_R7: assert property (@(posedge clk) disable iff (rst)
    mbx_core_wr |=> (pin_oe[MBX_PIN] == pin_out[MBX_PIN]));

  // R7: a completed host read without a new write clears the indicator
  assert_mbx_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (mbx_host_rd_done && !mbx_core_wr) |=> !pin_out[MBX_PIN]);

endmodule

bind dbg_evpin_ctrl evpin_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .FLD_W(FLD_W), .REG_W(REG_W), .MBX_PIN(MBX_PIN)
) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .addr_ch_en(addr_ch_en), .data_ch_en(data_ch_en),
  .mbx_core_wr(mbx_core_wr), .mbx_host_rd_done(mbx_host_rd_done)
);

// File: tb/test_dbg_evpin_ctrl.sv
module test_dbg_evpin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 7;
  localparam logic [6:0] ON_M  = 7'b0000100;
  localparam logic [6:0] OFF_M = 7'b0001000;
  localparam logic [6:0] CNT_M = 7'b1000100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0] pin_in = '0;
  logic [6:0] pin_out, pin_oe;
  logic mbx_core_wr = 1'b0, mbx_host_rd_done = 1'b0;
  logic [5:0] addr_ch_en;
  logic data_ch_en, evcnt_en, dbg_enter_pls, dbg_exc_pls, trc_on_pls, trc_off_pls;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_evpin_ctrl i_dbg_evpin_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .mbx_core_wr(mbx_core_wr), .mbx_host_rd_done(mbx_host_rd_done),
    .addr_ch_en(addr_ch_en), .data_ch_en(data_ch_en), .evcnt_en(evcnt_en),
    .dbg_enter_pls(dbg_enter_pls), .dbg_exc_pls(dbg_exc_pls),
    .trc_on_pls(trc_on_pls), .trc_off_pls(trc_off_pls)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    cyc(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulses_zero(input string tag);
    chk(tag, {dbg_enter_pls, dbg_exc_pls, trc_on_pls, trc_off_pls}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 / R10: pin 0 held high through reset
    pin_in = 7'b0000001;
    cyc(3);
    chk("R1 rdata in reset", reg_rdata, 16'hFFFC);
    chk("R1 oe in reset", pin_oe, 7'h00);
    pulses_zero("R1 pulses in reset");
    chk("R1 enables in reset", {addr_ch_en, data_ch_en, evcnt_en}, 8'h00);
    rst = 1'b0;
    cyc(2);
    chk("R10 no pulse yet", dbg_enter_pls, 1'b0);
    cyc(1);
    chk("R10 debug entry after reset", dbg_enter_pls, 1'b1);
    cyc(1);
    chk("R10 single pulse", dbg_enter_pls, 1'b0);
    pin_in = '0;
    cyc(3);

    // R2: register write and readback
    wr_cfg(16'hA5A7);
    chk("R2 readback", reg_rdata, 16'hA5A4);
    wr_cfg(16'h0000);
    chk("R2 readback zero", reg_rdata, 16'h0000);

    // R3..R6, R8, R9: every mode on every pin
    for (int p = 0; p < NPIN; p++) begin
      for (int c = 0; c < 4; c++) begin
        logic [15:0] cfg;
        logic is_in;
        logic [6:0] sel;
        cfg = 16'(c) << (2 + 2*p);
        is_in = (c != 2);
        sel = 7'(1) << p;
        wr_cfg(cfg);
        cyc(3);
        chk("R6 oe per mode", pin_oe, (c == 2) ? sel : 7'h00);
        pin_in = sel;
        cyc(2);
        pulses_zero("R3 latency not early");
        cyc(1);
        chk("R3 debug entry pulse", dbg_enter_pls, is_in && c == 3);
        chk("R4 debug exception pulse", dbg_exc_pls, is_in && c == 1);
        chk("R8 trace start", trc_on_pls, is_in && ON_M[p]);
        chk("R8 trace stop", trc_off_pls, is_in && OFF_M[p]);
        chk("R5 addr channel enable", addr_ch_en, (c == 0 && p < 6) ? sel[5:0] : 6'h00);
        chk("R5 data channel enable", data_ch_en, c == 0 && p == 6);
        chk("R9 counter enable", evcnt_en, is_in && CNT_M[p]);
        chk("R6 pin_out low", pin_out, 7'h00);
        cyc(1);
        pulses_zero("R3 held level one pulse");
        chk("R5 enable held", {addr_ch_en, data_ch_en}, (c == 0) ? {sel[5:0], sel[6]} : 7'h00);
        pin_in = '0;
        cyc(4);
        chk("R5 enable drops", {addr_ch_en, data_ch_en, evcnt_en}, 8'h00);
        pulses_zero("R3 no pulse on fall");
      end
    end

    // R7: mailbox indicator on pin 4, pin 5 also output
    wr_cfg(16'h2800);
    cyc(1);
    chk("R6 two outputs", pin_oe, 7'b0110000);
    chk("R7 empty at start", pin_out, 7'h00);
    mbx_core_wr = 1'b1;
    cyc(1);
    mbx_core_wr = 1'b0;
    chk("R7 set by core write", pin_out, 7'b0010000);
    pin_in = 7'b0110000;
    cyc(4);
    chk("R6 input ignored on output pins", {addr_ch_en, data_ch_en, evcnt_en, dbg_enter_pls, dbg_exc_pls, trc_on_pls, trc_off_pls}, 13'h0);
    chk("R7 flag held", pin_out, 7'b0010000);
    pin_in = '0;
    mbx_host_rd_done = 1'b1;
    cyc(1);
    mbx_host_rd_done = 1'b0;
    chk("R7 cleared by host read", pin_out, 7'h00);
    mbx_core_wr = 1'b1;
    mbx_host_rd_done = 1'b1;
    cyc(1);
    mbx_core_wr = 1'b0;
    mbx_host_rd_done = 1'b0;
    chk("R7 write wins", pin_out, 7'b0010000);
    wr_cfg(16'h0000);
    cyc(1);
    chk("R7 pin not driven in input mode", {pin_oe, pin_out}, 14'h0);
    mbx_host_rd_done = 1'b1;
    cyc(1);
    mbx_host_rd_done = 1'b0;

    // R3: second edge after release fires again (default register)
    wr_cfg(16'hFFFF);
    chk("R2 all ones readback", reg_rdata, 16'hFFFC);
    pin_in = 7'b0000001;
    cyc(3);
    chk("R3 default mode pulse", dbg_enter_pls, 1'b1);
    pin_in = '0;
    cyc(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule